// File: doc/BRIEF.md
# Early-Prompt-Late Code Correlator

This block is the correlation stage of a spread-spectrum code tracking channel. Each digitised IF sample is first stripped of its carrier by multiplying it with the signs of a local cosine and sine replica. This gives an in-phase product and a quadrature product. Each product is then multiplied by three copies of the local spreading code: early, prompt and late. The six results are summed over a block of samples whose length is set at run time. The default of 11999 samples is about one millisecond at a sample rate of about 12 MHz.

At the end of each block the six sums are dumped with a one-cycle strobe, and the accumulators start the next block from zero. Both arms are kept for each code offset. A discriminator built on them therefore works whether or not the carrier loop has locked phase. One cycle after each dump, the block also gives the early power minus the late power. The early code is the chip stream as it arrives. The prompt and late copies are taken from a delay line of past chips. The spacing is a number of accepted samples, normally half a chip. Samples are 8-bit two's complement by default. Built with a one-bit sample width, a sample bit of 1 counts as +1 and a bit of 0 counts as -1.

Top module: `epl_correlator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, dump_vld and eml_vld are low and all six sums and eml read zero.
- R2: The in-phase value is the sample negated when car_i_neg is 1 and unchanged when it is 0. The quadrature value follows car_q_neg in the same way. The sample is two's complement.
- R3: A code bit of 1 stands for +1 and 0 stands for -1. Each accepted sample adds its arm value times the code bit to the matching sum. The output order is IE, IP, IL (in-phase) and QE, QP, QL (quadrature).
- R4: The early code is the current chip input. The prompt code is the chip accepted `spacing` samples earlier, and the late code is the chip accepted 2×`spacing` samples earlier. A spacing of 0 makes all three equal. Spacings above MAX_SPACING act as MAX_SPACING. The chip history reads 0 after reset.
- R5: The block ends on the blk_len-th accepted sample, counted from reset or from the previous block end. A blk_len of 0 or 1 ends a block on every sample. The dump includes the sample that ends the block, and the next sample starts from zero.
- R6: dump_vld is high for one cycle, on the cycle after the clock edge that takes the block's last sample. The six sums hold their values until the next dump.
- R7: A cycle with in_vld low changes no sum, no sample count and no chip history.
- R8: On the cycle after each dump, eml_vld pulses and eml = (IE²+QE²)−(IL²+QL²), computed from the dumped sums. eml holds its value between pulses.
- R9: A 1-bit-style run at full scale does not wrap. This is a block of 11999 samples each worth −128, with either carrier sign, and gives ±1,535,872.
- R10: With blk_len 1 and samples on every cycle, a dump comes on every cycle, each holding that one sample's products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample accepted this cycle |
| sample | input | SAMPLE_W | IF sample, two's complement |
| car_i_neg | input | 1 | Cosine replica sign, 1 = negative |
| car_q_neg | input | 1 | Sine replica sign, 1 = negative |
| chip | input | 1 | Early code bit, 1 = +1 |
| spacing | input | clog2(MAX_SPACING+1) | Early-to-prompt offset in samples |
| blk_len | input | CNT_W | Samples per block |
| dump_vld | output | 1 | Sums valid strobe |
| ie | output | ACC_W | In-phase early sum |
| ip | output | ACC_W | In-phase prompt sum |
| il | output | ACC_W | In-phase late sum |
| qe | output | ACC_W | Quadrature early sum |
| qp | output | ACC_W | Quadrature prompt sum |
| ql | output | ACC_W | Quadrature late sum |
| eml_vld | output | 1 | Power difference valid strobe |
| eml | output | 2*ACC_W+2 | Early power minus late power |

## Verification
Two things can happen in the same cycle. The power difference for one block can come out while the next block is being dumped. A block can also end on the very sample that a new block would start from. Both are provoked by running blk_len 1 with a sample on every cycle, and by changing blk_len and spacing between samples. A behavioural model in the bench keeps its own sums, count and chip queue. Every clock, the bench compares the strobes, the six sums and eml against that model, so a dump that is late, missing or missing the final sample is caught in the cycle it occurs.

// File: rtl/epl_pkg.sv
package epl_pkg;
  // one bit per code offset, early is the undelayed chip
  typedef struct packed {
    logic early;
    logic prompt;
    logic late;
  } replica_t;

  localparam int NUM_ARMS = 2;
  localparam int NUM_TAPS = 3;
  localparam int NUM_LANES = NUM_ARMS * NUM_TAPS;
endpackage

// File: rtl/epl_code_delay.sv
module epl_code_delay
  import epl_pkg::*;
#(
  parameter int MAX_SPACING = 16,
  parameter int SP_W = $clog2(MAX_SPACING + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic            chip,
  input  logic [SP_W-1:0] spacing,
  output replica_t        rep
);
  localparam int DEPTH = 2 * MAX_SPACING;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] hist_q, hist_d;
  logic [SP_W-1:0]  sp_eff;
  logic [IDX_W-1:0] idx_p, idx_l;

  always_comb begin
    sp_eff = (spacing > SP_W'(MAX_SPACING)) ? SP_W'(MAX_SPACING) : spacing;
    idx_p  = IDX_W'(sp_eff) - IDX_W'(1);
    idx_l  = (IDX_W'(sp_eff) << 1) - IDX_W'(1);
  end

  always_comb begin
    hist_d = hist_q;
    if (in_vld) hist_d = {hist_q[DEPTH-2:0], chip};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    rep.early  = chip;
    rep.prompt = (sp_eff == '0) ? chip : hist_q[idx_p];
    rep.late   = (sp_eff == '0) ? chip : hist_q[idx_l];
  end
endmodule

// File: rtl/epl_wipeoff.sv
module epl_wipeoff #(
  parameter int SAMPLE_W = 8,
  parameter int ARM_W = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0]     sample,
  input  logic                    car_i_neg,
  input  logic                    car_q_neg,
  output logic signed [ARM_W-1:0] arm_i,
  output logic signed [ARM_W-1:0] arm_q
);
  logic signed [ARM_W-1:0] s_ext;

  generate
    if (SAMPLE_W == 1) begin : g_one_bit
      // a single bit stands for +1 or -1
      assign s_ext = sample[0] ? ARM_W'(1) : -ARM_W'(1);
    end else begin : g_multi_bit
      assign s_ext = {sample[SAMPLE_W-1], sample};
    end
  endgenerate

  always_comb begin
    arm_i = car_i_neg ? -s_ext : s_ext;
    arm_q = car_q_neg ? -s_ext : s_ext;
  end
endmodule

// File: rtl/epl_lane.sv
module epl_lane #(
  parameter int ARM_W = 9,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    restart,
  input  logic signed [ARM_W-1:0] val,
  input  logic                    code_bit,
  output logic signed [ACC_W-1:0] sum_next
);
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ARM_W:0]   prod;

  always_comb begin
    prod     = code_bit ? (ARM_W+1)'(val) : -(ARM_W+1)'(val);
    sum_next = acc_q + ACC_W'(prod);
    acc_d    = acc_q;
    if (en) acc_d = restart ? '0 : sum_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/epl_correlator.sv
module epl_correlator
  import epl_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int ACC_W       = 24,
  parameter int CNT_W       = 16,
  parameter int MAX_SPACING = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_vld,
  input  logic [SAMPLE_W-1:0]                sample,
  input  logic                               car_i_neg,
  input  logic                               car_q_neg,
  input  logic                               chip,
  input  logic [$clog2(MAX_SPACING+1)-1:0]   spacing,
  input  logic [CNT_W-1:0]                   blk_len,
  output logic                               dump_vld,
  output logic signed [ACC_W-1:0]            ie,
  output logic signed [ACC_W-1:0]            ip,
  output logic signed [ACC_W-1:0]            il,
  output logic signed [ACC_W-1:0]            qe,
  output logic signed [ACC_W-1:0]            qp,
  output logic signed [ACC_W-1:0]            ql,
  output logic                               eml_vld,
  output logic signed [2*ACC_W+1:0]          eml
);
  localparam int SP_W  = $clog2(MAX_SPACING + 1);
  localparam int ARM_W = SAMPLE_W + 1;
  localparam int EML_W = 2 * ACC_W + 2;

  replica_t                rep;
  logic signed [ARM_W-1:0] arm [NUM_ARMS];
  logic signed [ACC_W-1:0] lane_sum [NUM_LANES];
  logic signed [ACC_W-1:0] dump_q [NUM_LANES];
  logic signed [ACC_W-1:0] dump_d [NUM_LANES];
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    last;
  logic                    dump_vld_q;
  logic                    eml_vld_q;
  logic signed [EML_W-1:0] eml_q, eml_d;

  epl_code_delay #(.MAX_SPACING(MAX_SPACING), .SP_W(SP_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .chip(chip),
    .spacing(spacing), .rep(rep)
  );

  epl_wipeoff #(.SAMPLE_W(SAMPLE_W), .ARM_W(ARM_W)) u_wipe (
    .sample(sample), .car_i_neg(car_i_neg), .car_q_neg(car_q_neg),
    .arm_i(arm[0]), .arm_q(arm[1])
  );

  // block counter: end of block when this sample brings the count to blk_len
  always_comb begin
    last  = in_vld && ({1'b0, cnt_q} + (CNT_W+1)'(1) >= {1'b0, blk_len});
    cnt_d = cnt_q;
    if (in_vld) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  generate
    for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        logic code_bit;
        if (t == 0)      begin : g_e assign code_bit = rep.early;  end
        else if (t == 1) begin : g_p assign code_bit = rep.prompt; end
        else             begin : g_l assign code_bit = rep.late;   end

        epl_lane #(.ARM_W(ARM_W), .ACC_W(ACC_W)) u_lane (
          .clk(clk), .rst_n(rst_n), .en(in_vld), .restart(last),
          .val(arm[a]), .code_bit(code_bit),
          .sum_next(lane_sum[a*NUM_TAPS+t])
        );
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) dump_d[k] = last ? lane_sum[k] : dump_q[k];
  end

  // early minus late power from the dumped sums
  always_comb begin
    eml_d = eml_q;
    if (dump_vld_q)
      eml_d = EML_W'(dump_q[0]) * EML_W'(dump_q[0])
            + EML_W'(dump_q[3]) * EML_W'(dump_q[3])
            - EML_W'(dump_q[2]) * EML_W'(dump_q[2])
            - EML_W'(dump_q[5]) * EML_W'(dump_q[5]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dump_vld_q <= 1'b0;
      eml_vld_q  <= 1'b0;
      eml_q      <= '0;
      for (int k = 0; k < NUM_LANES; k++) dump_q[k] <= '0;
    end else begin
      cnt_q      <= cnt_d;
      dump_vld_q <= last;
      eml_vld_q  <= dump_vld_q;
      eml_q      <= eml_d;
      for (int k = 0; k < NUM_LANES; k++) dump_q[k] <= dump_d[k];
    end
  end

  assign dump_vld = dump_vld_q;
  assign ie       = dump_q[0];
  assign ip       = dump_q[1];
  assign il       = dump_q[2];
  assign qe       = dump_q[3];
  assign qp       = dump_q[4];
  assign ql       = dump_q[5];
  assign eml_vld  = eml_vld_q;
  assign eml      = eml_q;
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic [CNT_W-1:0]        blk_len,
  input logic                    dump_vld,
  input logic signed [ACC_W-1:0] ie,
  input logic signed [ACC_W-1:0] ql,
  input logic                    eml_vld
);
  assert_dump_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dump_vld |-> $past(in_vld));

  assert_sums_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_vld |-> ($stable(ie) && $stable(ql)));

  assert_idle_no_dump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !dump_vld);

  assert_eml_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dump_vld |=> eml_vld);

  assert_eml_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eml_vld |-> $past(dump_vld));

  assert_every_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && blk_len <= CNT_W'(1)) |=> dump_vld);
endmodule

bind epl_correlator epl_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_epl_checker (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .blk_len(blk_len),
  .dump_vld(dump_vld), .ie(ie), .ql(ql), .eml_vld(eml_vld)
);

// File: tb/test_epl_correlator.sv
module test_epl_correlator;
  localparam int SAMPLE_W = 8;
  localparam int ACC_W = 24;
  localparam int CNT_W = 16;
  localparam int MAX_SP = 16;
  localparam int SP_W = $clog2(MAX_SP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [SAMPLE_W-1:0] sample = '0;
  logic car_i_neg = 1'b0, car_q_neg = 1'b0, chip = 1'b0;
  logic [SP_W-1:0] spacing = '0;
  logic [CNT_W-1:0] blk_len = CNT_W'(8);
  logic dump_vld, eml_vld;
  logic signed [ACC_W-1:0] ie, ip, il, qe, qp, ql;
  logic signed [2*ACC_W+1:0] eml;

  always #2.5 clk = ~clk;

  epl_correlator #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
                   .MAX_SPACING(MAX_SP)) i_epl_correlator (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .sample(sample),
    .car_i_neg(car_i_neg), .car_q_neg(car_q_neg), .chip(chip),
    .spacing(spacing), .blk_len(blk_len), .dump_vld(dump_vld),
    .ie(ie), .ip(ip), .il(il), .qe(qe), .qp(qp), .ql(ql),
    .eml_vld(eml_vld), .eml(eml)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";
  int cfg_len = 8, cfg_sp = 0;

  // reference model state
  longint m_acc[6], m_dump[6], m_eml;
  bit m_dv, m_ev;
  int m_cnt;
  bit m_hist[$];

  task automatic chk(string req, string nm, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", req, nm, got, exp);
    end
  endtask

  task automatic compare_all();
    chk({cur_req, "/R6"}, "dump_vld", longint'(dump_vld), longint'(m_dv));
    chk({cur_req, "/R3"}, "IE", longint'(ie), m_dump[0]);
    chk({cur_req, "/R3"}, "IP", longint'(ip), m_dump[1]);
    chk({cur_req, "/R3"}, "IL", longint'(il), m_dump[2]);
    chk({cur_req, "/R3"}, "QE", longint'(qe), m_dump[3]);
    chk({cur_req, "/R3"}, "QP", longint'(qp), m_dump[4]);
    chk({cur_req, "/R3"}, "QL", longint'(ql), m_dump[5]);
    chk({cur_req, "/R8"}, "eml_vld", longint'(eml_vld), longint'(m_ev));
    chk({cur_req, "/R8"}, "eml", longint'(eml), m_eml);
  endtask

  // one clock: check what the last edge produced, predict the next, drive
  task automatic step(bit v, logic [7:0] s, bit ci, bit cq, bit c);
    longint w[2];
    bit r[3];
    int sp;
    bit nxt_dv;
    @(negedge clk);
    compare_all();
    nxt_dv = 0;
    m_ev = m_dv;
    if (m_dv)
      m_eml = m_dump[0]*m_dump[0] + m_dump[3]*m_dump[3]
            - m_dump[2]*m_dump[2] - m_dump[5]*m_dump[5];
    if (v) begin
      sp = (cfg_sp > MAX_SP) ? MAX_SP : cfg_sp;
      w[0] = ci ? -longint'($signed(s)) : longint'($signed(s));
      w[1] = cq ? -longint'($signed(s)) : longint'($signed(s));
      r[0] = c;
      r[1] = (sp == 0) ? c : m_hist[sp-1];
      r[2] = (sp == 0) ? c : m_hist[2*sp-1];
      for (int a = 0; a < 2; a++)
        for (int t = 0; t < 3; t++)
          m_acc[a*3+t] += r[t] ? w[a] : -w[a];
      if (m_cnt + 1 >= cfg_len) begin
        for (int k = 0; k < 6; k++) begin m_dump[k] = m_acc[k]; m_acc[k] = 0; end
        nxt_dv = 1;
        m_cnt = 0;
      end else m_cnt++;
      m_hist.push_front(c);
      void'(m_hist.pop_back());
    end
    m_dv = nxt_dv;
    in_vld = v; sample = s; car_i_neg = ci; car_q_neg = cq; chip = c;
    blk_len = CNT_W'(cfg_len); spacing = SP_W'(cfg_sp);
  endtask

  task automatic rand_run(int n, int gap_pct);
    for (int i = 0; i < n; i++)
      step($urandom_range(99) >= gap_pct, 8'($urandom_range(255)),
           1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 60000) begin #5; wd++; end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) begin m_acc[k] = 0; m_dump[k] = 0; end
    m_eml = 0; m_dv = 0; m_ev = 0; m_cnt = 0;
    for (int k = 0; k < 2*MAX_SP; k++) m_hist.push_back(1'b0);

    // R1: outputs during and right after reset
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1'b1;

    // R2/R3: carrier signs and code signs, spacing 0
    cur_req = "R2"; cfg_len = 8; cfg_sp = 0;
    rand_run(200, 0);

    // R4: nonzero spacing, including above the maximum
    cur_req = "R4"; cfg_len = 20; cfg_sp = 3;
    rand_run(300, 0);
    cfg_sp = 16; rand_run(200, 0);
    cfg_sp = 20; rand_run(200, 0);

    // R7: gaps in the stream
    cur_req = "R7"; cfg_sp = 2; cfg_len = 10;
    rand_run(400, 60);

    // R5: block length changes, including 0
    cur_req = "R5"; cfg_len = 5; rand_run(120, 20);
    cfg_len = 0; rand_run(20, 0);
    cfg_len = 7; rand_run(150, 10);

    // R10: a dump every cycle, eml overlapping the next dump
    cur_req = "R10"; cfg_len = 1; cfg_sp = 1;
    rand_run(60, 0);

    // R9: full-scale block without wrap
    cur_req = "R9"; cfg_len = 11999; cfg_sp = 0;
    for (int i = 0; i < 11999; i++) step(1, 8'h80, 1, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 0);
    chk("R9", "IE full scale", longint'(ie), 64'sd1535872);
    chk("R9", "QE full scale", longint'(qe), -64'sd1535872);

    rand_run(10, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule